// File: doc/BRIEF.md
# Single-Precision Floating-Point Comparator

This block compares two single-precision floating-point operands. The ordering outputs less-than, equal, greater-than and unordered are combinational, and exactly one of them is high in every cycle. The operand magnitude is ordered by treating the packed exponent and fraction bits as one unsigned integer. That integer comparison is valid because the exponent is biased and sits above the fraction. The two sign bits then settle the signed order. Both zero encodings compare equal. Any operand with an all-ones exponent and a nonzero fraction is a NaN and makes the pair unordered. Infinities need no special handling, because they already sort above every finite value.

A compare step also loads a registered condition bit. When the compare strobe is high at a clock edge, the condition bit takes the truth value of the predicate selected on that edge. The condition bit then holds that value until the next strobe. There is no streaming data path, so there is no valid/ready handshake and no back-pressure. The operands and the strobe are plain control inputs, sampled each cycle.

The exponent and fraction widths are parameters. The same logic can therefore be built for smaller formats; single precision is the default.

Top module: `fp_cmp_top`

## Requirements
- R1: If either operand has an exponent of all ones and a nonzero fraction (a NaN), then is_unord is 1 and is_lt, is_eq and is_gt are all 0.
- R2: Any two zero operands compare equal regardless of their signs. A zero has exponent 0 and fraction 0, and bit 31 is the sign.
- R3: In every cycle exactly one of is_lt, is_eq, is_gt and is_unord is 1.
- R4: For two non-NaN operands that are both positive, the order follows the magnitude. The magnitude is the unsigned value of bits 30..0 (exponent in 30..23, fraction in 22..0).
- R5: When the signs differ and the operands are not both zero, the operand with sign bit 1 is the lesser.
- R6: When both operands are negative and not NaN, the order is the reverse of their magnitude order.
- R7: An infinity (exponent all ones, fraction 0) orders above or below every finite value of its sign, and an infinity equals another infinity of the same sign.
- R8: On a clock edge with cmp_strobe high, cond_flag loads the selected predicate. The encodings are pred_sel 00 equal, 01 less-than, 10 less-or-equal and 11 unordered. The new value is visible after that edge.
- R9: While cmp_strobe is low, cond_flag keeps its value, whatever the operands and pred_sel do.
- R10: While rst_n is low, cond_flag is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_a | input | 32 | Left operand (sign, exponent, fraction) |
| op_b | input | 32 | Right operand |
| pred_sel | input | 2 | Predicate for the condition bit |
| cmp_strobe | input | 1 | Load cond_flag at this edge |
| is_lt | output | 1 | op_a < op_b |
| is_eq | output | 1 | op_a == op_b |
| is_gt | output | 1 | op_a > op_b |
| is_unord | output | 1 | At least one operand is NaN |
| cond_flag | output | 1 | Registered predicate result |

## Verification
Some properties are checked by assertions on every cycle:
- the ordering outputs are one-hot;
- a NaN always yields unordered;
- a pair of zeros always yields equal;
- cond_flag loads on a strobe and holds without one.

Whether the order of a particular pair is right cannot be seen from such local properties. This covers sign reversal for negative pairs, infinities against finite values, and the boundary between subnormals and normals. The bench therefore sweeps every operand pair of a 6-bit format. For each pair it computes the expected order from the arithmetic value of each operand. It checks the four combinational outputs and the condition bit loaded for a predicate chosen per pair.

// File: rtl/fpc_pkg.sv
package fpc_pkg;

  typedef enum logic [1:0] {
    PRED_EQ = 2'b00,
    PRED_LT = 2'b01,
    PRED_LE = 2'b10,
    PRED_UN = 2'b11
  } pred_e;

  typedef struct packed {
    logic is_nan;
    logic is_zero;
  } fclass_t;

  typedef struct packed {
    logic lt;
    logic eq;
    logic gt;
    logic un;
  } rel_t;

endpackage

// File: rtl/fpc_classify.sv
module fpc_classify
  import fpc_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int MAG_W = EXP_W + FRAC_W
) (
  input  logic [MAG_W:0]   op,
  output logic             sign,
  output logic [MAG_W-1:0] mag,
  output fclass_t          cls
);

  logic [EXP_W-1:0]  exp_f;
  logic [FRAC_W-1:0] frac_f;

  assign sign   = op[MAG_W];
  assign mag    = op[MAG_W-1:0];
  assign exp_f  = op[MAG_W-1:FRAC_W];
  assign frac_f = op[FRAC_W-1:0];

  always_comb begin
    cls.is_nan  = (&exp_f) & (|frac_f);
    cls.is_zero = ~(|exp_f) & ~(|frac_f);
  end

endmodule

// File: rtl/fpc_magcmp.sv
module fpc_magcmp #(
  parameter int W       = 31,
  parameter int SLICE_W = 4,
  localparam int NSLICE = (W + SLICE_W - 1) / SLICE_W,
  localparam int PW     = NSLICE * SLICE_W
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic         lt,
  output logic         eq,
  output logic         gt
);

  logic [PW-1:0]     pa, pb;
  logic [NSLICE-1:0] s_lt, s_eq;

  always_comb begin
    pa = '0;
    pb = '0;
    pa[W-1:0] = a;
    pb[W-1:0] = b;
  end

  for (genvar g = 0; g < NSLICE; g++) begin : g_slice
    logic [SLICE_W-1:0] sa, sb;
    assign sa      = pa[g*SLICE_W +: SLICE_W];
    assign sb      = pb[g*SLICE_W +: SLICE_W];
    assign s_lt[g] = (sa < sb);
    assign s_eq[g] = (sa == sb);
  end

  logic found, lt_r;
  always_comb begin
    found = 1'b0;
    lt_r  = 1'b0;
    for (int i = NSLICE - 1; i >= 0; i--) begin
      if (!found && !s_eq[i]) begin
        found = 1'b1;
        lt_r  = s_lt[i];
      end
    end
  end

  assign lt = found & lt_r;
  assign gt = found & ~lt_r;
  assign eq = ~found;

endmodule

// File: rtl/fpc_resolve.sv
module fpc_resolve
  import fpc_pkg::*;
(
  input  logic    sign_a,
  input  logic    sign_b,
  input  fclass_t cls_a,
  input  fclass_t cls_b,
  input  logic    m_lt,
  input  logic    m_eq,
  input  logic    m_gt,
  output rel_t    rel
);

  always_comb begin
    rel = '0;
    if (cls_a.is_nan || cls_b.is_nan) begin
      rel.un = 1'b1;
    end else if (cls_a.is_zero && cls_b.is_zero) begin
      rel.eq = 1'b1;
    end else if (sign_a != sign_b) begin
      rel.lt = sign_a;
      rel.gt = sign_b;
    end else if (!sign_a) begin
      rel.lt = m_lt;
      rel.eq = m_eq;
      rel.gt = m_gt;
    end else begin
      rel.lt = m_gt;
      rel.eq = m_eq;
      rel.gt = m_lt;
    end
  end

endmodule

// File: rtl/fpc_condreg.sv
module fpc_condreg
  import fpc_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  strobe,
  input  pred_e sel,
  input  rel_t  rel,
  output logic  flag
);

  logic pick;
  always_comb begin
    unique case (sel)
      PRED_EQ: pick = rel.eq;
      PRED_LT: pick = rel.lt;
      PRED_LE: pick = rel.lt | rel.eq;
      default: pick = rel.un;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      flag <= 1'b0;
    else if (strobe) flag <= pick;
  end

  p_flag_le_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && sel == PRED_LE) |=> (flag == $past(rel.lt || rel.eq)));

  p_flag_un_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && sel == PRED_UN) |=> (flag == $past(rel.un)));

  p_flag_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe |=> $stable(flag));

endmodule

// File: rtl/fp_cmp_top.sv
module fp_cmp_top
  import fpc_pkg::*;
#(
  parameter int EXP_W   = 8,
  parameter int FRAC_W  = 23,
  parameter int SLICE_W = 4,
  localparam int MAG_W  = EXP_W + FRAC_W,
  localparam int OP_W   = MAG_W + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [OP_W-1:0] op_a,
  input  logic [OP_W-1:0] op_b,
  input  logic [1:0]      pred_sel,
  input  logic            cmp_strobe,
  output logic            is_lt,
  output logic            is_eq,
  output logic            is_gt,
  output logic            is_unord,
  output logic            cond_flag
);

  logic [OP_W-1:0]  ops  [2];
  logic [1:0]       sgn;
  logic [MAG_W-1:0] mags [2];
  fclass_t          cls  [2];

  assign ops[0] = op_a;
  assign ops[1] = op_b;

  for (genvar k = 0; k < 2; k++) begin : g_cls
    fpc_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
      .op   (ops[k]),
      .sign (sgn[k]),
      .mag  (mags[k]),
      .cls  (cls[k])
    );
  end

  logic m_lt, m_eq, m_gt;
  fpc_magcmp #(.W(MAG_W), .SLICE_W(SLICE_W)) u_mag (
    .a  (mags[0]),
    .b  (mags[1]),
    .lt (m_lt),
    .eq (m_eq),
    .gt (m_gt)
  );

  rel_t rel;
  fpc_resolve u_res (
    .sign_a (sgn[0]),
    .sign_b (sgn[1]),
    .cls_a  (cls[0]),
    .cls_b  (cls[1]),
    .m_lt   (m_lt),
    .m_eq   (m_eq),
    .m_gt   (m_gt),
    .rel    (rel)
  );

  assign is_lt    = rel.lt;
  assign is_eq    = rel.eq;
  assign is_gt    = rel.gt;
  assign is_unord = rel.un;

  fpc_condreg u_cond (
    .clk    (clk),
    .rst_n  (rst_n),
    .strobe (cmp_strobe),
    .sel    (pred_e'(pred_sel)),
    .rel    (rel),
    .flag   (cond_flag)
  );

  p_nan_unord_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cls[0].is_nan || cls[1].is_nan) |-> (is_unord && !is_lt && !is_eq && !is_gt));

  p_zero_eq_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cls[0].is_zero && cls[1].is_zero) |-> is_eq);

  p_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({is_lt, is_eq, is_gt, is_unord}) == 1);

  p_sign_split_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_unord && sgn[0] && !sgn[1] && !(cls[0].is_zero && cls[1].is_zero)) |-> is_lt);

endmodule

// File: tb/sim_fp_cmp_top.sv
`timescale 1ns/1ps
module sim_fp_cmp_top;

  localparam int EW = 3;
  localparam int FW = 2;
  localparam int OW = EW + FW + 1;
  localparam int NV = 1 << OW;
  localparam int EMAX = (1 << EW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [OW-1:0] op_a = '0, op_b = '0;
  logic [1:0] pred_sel = 2'b00;
  logic cmp_strobe = 1'b0;
  logic is_lt, is_eq, is_gt, is_unord, cond_flag;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  fp_cmp_top #(.EXP_W(EW), .FRAC_W(FW), .SLICE_W(2)) u0 (
    .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b),
    .pred_sel(pred_sel), .cmp_strobe(cmp_strobe),
    .is_lt(is_lt), .is_eq(is_eq), .is_gt(is_gt),
    .is_unord(is_unord), .cond_flag(cond_flag)
  );

  function automatic bit f_nan(input logic [OW-1:0] v);
    return (v[OW-2:FW] == EMAX[EW-1:0]) && (v[FW-1:0] != 0);
  endfunction

  function automatic bit f_inf(input logic [OW-1:0] v);
    return (v[OW-2:FW] == EMAX[EW-1:0]) && (v[FW-1:0] == 0);
  endfunction

  // arithmetic value in units of the smallest subnormal step
  function automatic longint f_val(input logic [OW-1:0] v);
    longint m;
    int e;
    int f;
    e = int'(v[OW-2:FW]);
    f = int'(v[FW-1:0]);
    if (e == EMAX)   m = 64'd1 << 40;
    else if (e == 0) m = f;
    else             m = longint'((1 << FW) | f) << (e - 1);
    return v[OW-1] ? -m : m;
  endfunction

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp_v);
    total++;
    if (act !== exp_v) begin
      bad++;
      $display("FAIL %s a=%h b=%h actual=%b expected=%b", req, op_a, op_b, act, exp_v);
    end
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R10: cond_flag held at 0 in reset, even with a strobe and a true predicate
    op_a = OW'(5); op_b = OW'(5); pred_sel = 2'b00; cmp_strobe = 1'b1;
    repeat (3) @(negedge clk);
    check("R10", {3'b0, cond_flag}, 4'b0000);
    cmp_strobe = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    check("R10", {3'b0, cond_flag}, 4'b0000);

    for (int ia = 0; ia < NV; ia++) begin
      for (int ib = 0; ib < NV; ib++) begin
        logic [3:0] ex;
        logic exf;
        string rq;
        logic [OW-1:0] a, b;
        a = OW'(ia);
        b = OW'(ib);
        @(negedge clk);
        op_a = a; op_b = b;
        pred_sel = 2'(ia + ib);
        cmp_strobe = 1'b1;
        #1;
        if (f_nan(a) || f_nan(b)) begin
          ex = 4'b0001; rq = "R1";
        end else begin
          longint va, vb;
          va = f_val(a); vb = f_val(b);
          ex = (va < vb) ? 4'b1000 : (va == vb) ? 4'b0100 : 4'b0010;
          if (va == 0 && vb == 0)          rq = "R2";
          else if (f_inf(a) || f_inf(b))   rq = "R7";
          else if (a[OW-1] != b[OW-1])     rq = "R5";
          else if (a[OW-1])                rq = "R6";
          else                             rq = "R4";
        end
        check(rq, {is_lt, is_eq, is_gt, is_unord}, ex);
        check("R3", 4'($countones({is_lt, is_eq, is_gt, is_unord})), 4'd1);
        case (pred_sel)
          2'b00:   exf = ex[2];
          2'b01:   exf = ex[3];
          2'b10:   exf = ex[3] | ex[2];
          default: exf = ex[0];
        endcase
        @(negedge clk);
        cmp_strobe = 1'b0;
        check("R8", {3'b0, cond_flag}, {3'b0, exf});
      end
    end

    // R9: without a strobe, cond_flag stays while inputs change
    begin
      logic held;
      held = cond_flag;
      for (int k = 0; k < 20; k++) begin
        @(negedge clk);
        op_a = OW'(k * 7); op_b = OW'(k * 3 + 1); pred_sel = 2'(k);
        @(negedge clk);
        check("R9", {3'b0, cond_flag}, {3'b0, held});
      end
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule